// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects level-sensitive interrupt requests from twenty-five on-chip sources and one encoded four-bit external level input. It picks the highest-priority request that is pending, unmasked and enabled, and presents a request line and a 12-bit event code to the processor. Sources that belong to one peripheral form a group that shares a single 4-bit priority field. Three 16-bit priority registers hold twelve such fields.

Software reaches the block through a small register port. It can write and read the three priority registers. It masks and unmasks sources through a pair of write addresses, one that sets bits and one that clears them. It can also read or overwrite the event code register. When the processor accepts an interrupt it pulses an acknowledge, and the event code register captures the code on offer in that cycle. The processor supplies its current interrupt mask level, and only a winner whose priority is strictly above that level raises the request line.

Top module: `pic_top`

## Requirements
- R1: After reset the priority registers, the mask and the event code register read 0, `irq_req` is low and `irq_code` is 0.
- R2: Register addresses are 0 (priority register A), 1 (priority register B), 2 (priority register C), 3 (mask set; reads the mask), 4 (mask clear; reads the mask) and 5 (event code). Priority registers keep `wdata[15:0]`. The fields are: A[15:12] timer 0, A[11:8] timer 1, A[7:4] timer-2 group, A[3:0] clock group, B[15:12] watchdog, B[11:8] refresh group, B[7:4] serial group, C[15:12] GPIO, C[11:8] DMA group, C[7:4] FIFO-serial group, C[3:0] debug. B[3:0] is unused and always reads 0.
- R3: A source whose priority field is 0 never raises a request.
- R4: The eligible source with the highest priority wins. On equal priority, the lower event code wins.
- R5: On-chip source index i (bit i of `src_req`) has event code 0x400+0x20*i for i 0..13, 0x600+0x20*(i-14) for i 14..20 and 0x700+0x20*(i-21) for i 21..24. Indices 0..13 are timer 0, timer 1, timer-2 underflow and capture, three clock sources, four serial sources, watchdog and two refresh sources. Indices 14..20 are debug, GPIO, DMA channel end 0..3 and DMA address error. Indices 21..24 are the four FIFO-serial sources.
- R6: An external level value n in 0..14 is a request with code 0x200+0x20*n and priority 15-n. The value 15 means no request.
- R7: Writing address 3 sets the mask bits that are 1 in `wdata`, and writing address 4 clears them. Bits written as 0 are left unchanged. Mask bit i blocks source i. The external level cannot be masked.
- R8: `irq_req` is high only when the winning priority is strictly greater than `cpu_lvl`. `irq_code` is the winner's code when `irq_req` is high and 0 otherwise.
- R9: An `int_ack` pulse loads `irq_code` into the event code register. A software write to it keeps only `wdata[10:0]`. If both happen in the same cycle, the software write wins.
- R10: `irq_req` and `irq_code` are registered. They reflect the inputs and register state one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 25 | Level requests from on-chip sources |
| ext_lvl | input | 4 | Encoded external level, 15 = idle |
| cpu_lvl | input | 4 | Processor interrupt mask level |
| int_ack | input | 1 | Interrupt accepted strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_code | output | 12 | Event code of the winning request |

## Verification
A wrong priority field mapping or a stale mask bit shows up as the wrong event code, or as a request line in the wrong state. It appears on `irq_code` or `irq_req` at the first clock edge after the stimulus that exposes it. A broken tie rule is only visible when two sources share a priority, so the bench sweeps dense request patterns with random field values. A corrupted event code register is seen on the next read of address 5.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC   = 25;
  localparam int NFLD   = 12;
  localparam int PRI_W  = 4;
  localparam int CODE_W = 12;
  localparam int DATA_W = 32;
  localparam int REG_W  = 16;
  localparam int EVT_KEEP = 11;

  typedef enum logic [2:0] {
    RA_PRI_A   = 3'd0,
    RA_PRI_B   = 3'd1,
    RA_PRI_C   = 3'd2,
    RA_MSK_SET = 3'd3,
    RA_MSK_CLR = 3'd4,
    RA_EVENT   = 3'd5
  } reg_addr_e;

  // Event code of on-chip source i; index order equals code order.
  function automatic logic [CODE_W-1:0] src_code(input int i);
    if (i < 14)      return CODE_W'(12'h400 + 32 * i);
    else if (i < 21) return CODE_W'(12'h600 + 32 * (i - 14));
    else             return CODE_W'(12'h700 + 32 * (i - 21));
  endfunction

  // Field index = register*4 + nibble (nibble 0 = bits [3:0]).
  function automatic int src_field(input int i);
    if (i == 0)       return 3;   // A[15:12]
    else if (i == 1)  return 2;   // A[11:8]
    else if (i <= 3)  return 1;   // A[7:4]
    else if (i <= 6)  return 0;   // A[3:0]
    else if (i <= 10) return 5;   // B[7:4]
    else if (i == 11) return 7;   // B[15:12]
    else if (i <= 13) return 6;   // B[11:8]
    else if (i == 14) return 8;   // C[3:0]
    else if (i == 15) return 11;  // C[15:12]
    else if (i <= 20) return 10;  // C[11:8]
    else              return 9;   // C[7:4]
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [2:0]             addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   ack,
  input  logic [CODE_W-1:0]      ack_code,
  output logic [NFLD*PRI_W-1:0]  pri_flds,
  output logic [NSRC-1:0]        mask,
  output logic [DATA_W-1:0]      rdata
);
  localparam int UNUSED_FLD = 4;

  logic [NFLD*PRI_W-1:0] pri_q, pri_d;
  logic [NSRC-1:0]       mask_q, mask_d;
  logic [CODE_W-1:0]     evt_q, evt_d;
  logic                  pri_en, mask_en, evt_en;

  always_comb begin
    pri_d   = pri_q;
    mask_d  = mask_q;
    evt_d   = evt_q;
    pri_en  = 1'b0;
    mask_en = 1'b0;
    evt_en  = 1'b0;
    if (wr) begin
      case (addr)
        RA_PRI_A: begin pri_en = 1'b1; pri_d[0*REG_W +: REG_W] = wdata[REG_W-1:0]; end
        RA_PRI_B: begin pri_en = 1'b1; pri_d[1*REG_W +: REG_W] = wdata[REG_W-1:0]; end
        RA_PRI_C: begin pri_en = 1'b1; pri_d[2*REG_W +: REG_W] = wdata[REG_W-1:0]; end
        RA_MSK_SET: begin mask_en = 1'b1; mask_d = mask_q | wdata[NSRC-1:0]; end
        RA_MSK_CLR: begin mask_en = 1'b1; mask_d = mask_q & ~wdata[NSRC-1:0]; end
        RA_EVENT: begin
          evt_en = 1'b1;
          evt_d  = {{(CODE_W-EVT_KEEP){1'b0}}, wdata[EVT_KEEP-1:0]};
        end
        default: ;
      endcase
    end
    pri_d[UNUSED_FLD*PRI_W +: PRI_W] = '0;
    if (ack && !evt_en) begin
      evt_en = 1'b1;
      evt_d  = ack_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      mask_q <= '0;
      evt_q  <= '0;
    end else begin
      if (pri_en)  pri_q  <= pri_d;
      if (mask_en) mask_q <= mask_d;
      if (evt_en)  evt_q  <= evt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_PRI_A:   rdata = DATA_W'(pri_q[0*REG_W +: REG_W]);
      RA_PRI_B:   rdata = DATA_W'(pri_q[1*REG_W +: REG_W]);
      RA_PRI_C:   rdata = DATA_W'(pri_q[2*REG_W +: REG_W]);
      RA_MSK_SET,
      RA_MSK_CLR: rdata = DATA_W'(mask_q);
      RA_EVENT:   rdata = DATA_W'(evt_q);
      default:    rdata = '0;
    endcase
  end

  assign pri_flds = pri_q;
  assign mask     = mask_q;

  a_r2_unused_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_PRI_B) |-> (rdata[PRI_W-1:0] == '0));
  a_r7_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_MSK_SET) |=>
      ((mask_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_MSK_CLR) |=> ((mask_q & $past(wdata[NSRC-1:0])) == '0));
  a_r9_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(wr && addr == RA_EVENT)) |=> (evt_q == $past(ack_code)));
  a_r9_sw_width: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_EVENT) |=> (evt_q[CODE_W-1:EVT_KEEP] == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC-1:0]        mask,
  input  logic [NFLD*PRI_W-1:0]  pri_flds,
  input  logic [PRI_W-1:0]       ext_lvl,
  output logic [PRI_W-1:0]       best_pri,
  output logic [CODE_W-1:0]      best_code
);
  localparam logic [PRI_W-1:0] EXT_IDLE = '1;

  logic [PRI_W-1:0] src_pri [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_pri[g] = (req[g] && !mask[g]) ?
                        pri_flds[src_field(g)*PRI_W +: PRI_W] : '0;
  end

  // External codes lie below every on-chip code, so it seeds the scan;
  // ascending scan with strict compare keeps the lower code on ties.
  always_comb begin
    if (ext_lvl != EXT_IDLE) begin
      best_pri  = EXT_IDLE - ext_lvl;
      best_code = CODE_W'(12'h200) + {3'b000, ext_lvl, 5'b00000};
    end else begin
      best_pri  = '0;
      best_code = '0;
    end
    for (int i = 0; i < NSRC; i++) begin
      if (src_pri[i] > best_pri) begin
        best_pri  = src_pri[i];
        best_code = src_code(i);
      end
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [24:0] src_req,
  input  logic [3:0]  ext_lvl,
  input  logic [3:0]  cpu_lvl,
  input  logic        int_ack,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req,
  output logic [11:0] irq_code
);
  logic [NFLD*PRI_W-1:0] pri_flds;
  logic [NSRC-1:0]       mask;
  logic [PRI_W-1:0]      best_pri;
  logic [CODE_W-1:0]     best_code;
  logic                  irq_d, irq_q;
  logic [CODE_W-1:0]     code_d, code_q;

  pic_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ack      (int_ack),
    .ack_code (code_q),
    .pri_flds (pri_flds),
    .mask     (mask),
    .rdata    (reg_rdata)
  );

  pic_arbiter u_arb (
    .req       (src_req),
    .mask      (mask),
    .pri_flds  (pri_flds),
    .ext_lvl   (ext_lvl),
    .best_pri  (best_pri),
    .best_code (best_code)
  );

  always_comb begin
    irq_d  = (best_pri > cpu_lvl);
    code_d = irq_d ? best_code : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      code_q <= '0;
    end else begin
      irq_q  <= irq_d;
      code_q <= code_d;
    end
  end

  assign irq_req  = irq_q;
  assign irq_code = code_q;

  a_r8_code_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code != '0));
  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_code == '0));
  a_r5_code_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code[4:0] == 5'd0 && irq_code >= 12'h200 && irq_code <= 12'h760));
  a_r3_zero_prio_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_flds == '0 && ext_lvl == 4'hF) |=> !irq_req);
endmodule

// File: tb/tb_pic_top.sv
module tb_pic_top;
  logic        clk;
  logic        rst_n;
  logic [24:0] src_req;
  logic [3:0]  ext_lvl;
  logic [3:0]  cpu_lvl;
  logic        int_ack;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [11:0] irq_code;

  int checks = 0;
  int errors = 0;
  logic [15:0] pa, pb, pc;
  logic [24:0] mk;
  logic [31:0] rng = 32'h1234_5678;

  pic_top dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .ext_lvl(ext_lvl),
    .cpu_lvl(cpu_lvl), .int_ack(int_ack), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic logic [11:0] mcode(input int i);
    if (i < 14)      return 12'(12'h400 + 32 * i);
    else if (i < 21) return 12'(12'h600 + 32 * (i - 14));
    else             return 12'(12'h700 + 32 * (i - 21));
  endfunction

  function automatic logic [3:0] mpri(input int i);
    int f;
    logic [15:0] r;
    if (i == 0) f = 3; else if (i == 1) f = 2; else if (i <= 3) f = 1;
    else if (i <= 6) f = 0; else if (i <= 10) f = 5; else if (i == 11) f = 7;
    else if (i <= 13) f = 6; else if (i == 14) f = 8; else if (i == 15) f = 11;
    else if (i <= 20) f = 10; else f = 9;
    r = (f < 4) ? pa : (f < 8) ? pb : pc;
    return r[(f % 4) * 4 +: 4];
  endfunction

  function automatic logic [12:0] model();
    logic [3:0]  bp;
    logic [11:0] bc;
    bp = 0; bc = 0;
    if (ext_lvl != 4'hF) begin
      bp = 4'hF - ext_lvl;
      bc = 12'(12'h200 + 32 * ext_lvl);
    end
    for (int i = 0; i < 25; i++)
      if (src_req[i] && !mk[i] && mpri(i) > bp) begin
        bp = mpri(i);
        bc = mcode(i);
      end
    if (bp > cpu_lvl) return {1'b1, bc};
    return 13'd0;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_pri(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    wr_reg(3'd0, {16'hFFFF, a});
    wr_reg(3'd1, {16'hFFFF, b});
    wr_reg(3'd2, {16'hFFFF, c});
    pa = a; pb = {b[15:4], 4'h0}; pc = c;
  endtask

  task automatic set_mask(input logic [24:0] m);
    wr_reg(3'd4, 32'hFFFF_FFFF);
    wr_reg(3'd3, {7'd0, m});
    mk = m;
  endtask

  // inputs already set at a negedge; wait one edge and compare
  task automatic expect_out(input string tag);
    logic [12:0] e;
    e = model();
    @(negedge clk);
    check({tag, " irq"}, {31'd0, irq_req}, {31'd0, e[12]});
    check({tag, " code"}, {20'd0, irq_code}, {20'd0, e[11:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_req = '0; ext_lvl = 4'hF; cpu_lvl = 4'h0;
    int_ack = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pa = 0; pb = 0; pc = 0; mk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq_req}, 0);
    check("R1 code", {20'd0, irq_code}, 0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), d);
      check("R1 reg", d, 0);
    end

    // R2 read back, unused nibble
    set_pri(16'h1234, 16'h567F, 16'h9ABC);
    rd_reg(3'd0, d); check("R2 A", d, 32'h1234);
    rd_reg(3'd1, d); check("R2 B unused nibble", d, 32'h5670);
    rd_reg(3'd2, d); check("R2 C", d, 32'h9ABC);
    rd_reg(3'd6, d); check("R2 unmapped", d, 0);

    // R10 registered output: no change before the edge
    set_pri(16'hFFFF, 16'hFFF0, 16'hFFFF);
    src_req = 25'd1;
    #1;
    check("R10 no comb path", {31'd0, irq_req}, 0);
    @(negedge clk);
    check("R10 after one edge", {20'd0, irq_code}, 32'h400);

    // R5 each source alone, with field map
    set_pri(16'h4321, 16'h8760, 16'hCBA9);
    for (int i = 0; i < 25; i++) begin
      src_req = 25'd1 << i;
      expect_out("R5 single source");
      check("R5 code value", {20'd0, irq_code}, {20'd0, mcode(i)});
    end

    // R3 zero priority disables
    set_pri(16'h0000, 16'h0000, 16'h0000);
    src_req = '1;
    expect_out("R3 all zero");
    set_pri(16'h0F00, 16'h0000, 16'h0000);
    expect_out("R3 only timer1 enabled");
    check("R3 timer1 code", {20'd0, irq_code}, 32'h420);

    // R4 tie: lower code wins
    set_pri(16'h7700, 16'h0000, 16'h0000);
    src_req = 25'b11;
    expect_out("R4 tie");
    check("R4 tie lower code", {20'd0, irq_code}, 32'h400);
    src_req = 25'b10;
    set_pri(16'h3900, 16'h0000, 16'h0000);
    src_req = 25'b11;
    expect_out("R4 higher wins");

    // R6 external sweep and R8 boundary
    set_pri(0, 0, 0);
    src_req = '0;
    for (int n = 0; n < 16; n++) begin
      ext_lvl = 4'(n); cpu_lvl = 4'h0;
      @(negedge clk);
      check("R6 ext irq", {31'd0, irq_req}, (n == 15) ? 0 : 1);
      check("R6 ext code", {20'd0, irq_code}, (n == 15) ? 0 : 32'(12'h200 + 32 * n));
      if (n < 15) begin
        cpu_lvl = 4'(15 - n);
        @(negedge clk);
        check("R8 level equal blocks", {31'd0, irq_req}, 0);
        cpu_lvl = 4'(14 - n);
        @(negedge clk);
        check("R8 level below passes", {31'd0, irq_req}, 1);
      end
    end
    ext_lvl = 4'hF; cpu_lvl = 0;

    // R7 mask set/clear
    wr_reg(3'd3, 32'h0000_00F0);
    wr_reg(3'd3, 32'h0000_0003);
    rd_reg(3'd3, d); check("R7 set ors", d, 32'hF3);
    wr_reg(3'd4, 32'h0000_0011);
    rd_reg(3'd4, d); check("R7 clear", d, 32'hE2);
    set_mask(25'd1);
    set_pri(16'hF000, 0, 0);
    src_req = 25'd1;
    expect_out("R7 masked source ignored");
    ext_lvl = 4'd10;
    expect_out("R7 ext not maskable");
    ext_lvl = 4'hF;
    set_mask(0);

    // R9 event register
    set_pri(16'h0F00, 0, 0);
    src_req = 25'b10;
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    rd_reg(3'd5, d); check("R9 ack loads code", d, 32'h420);
    wr_reg(3'd5, 32'hFFFF_FFFF);
    rd_reg(3'd5, d); check("R9 write keeps 11 bits", d, 32'h7FF);
    @(negedge clk);
    int_ack = 1'b1; reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h123;
    @(negedge clk);
    int_ack = 1'b0; reg_wr = 1'b0;
    rd_reg(3'd5, d); check("R9 write beats ack", d, 32'h123);

    // R4/R6/R7/R8 random sweep
    for (int it = 0; it < 300; it++) begin
      logic [31:0] r1, r2, r3;
      r1 = rnd(); r2 = rnd(); r3 = rnd();
      set_pri(r1[15:0], r1[31:16], r2[15:0]);
      set_mask(r3[24:0] & rnd()[24:0]);
      src_req = rnd()[24:0];
      r3 = rnd();
      cpu_lvl = r3[3:0];
      ext_lvl = r3[8] ? 4'hF : r3[7:4];
      expect_out("R4 R8 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule